// File: doc/BRIEF.md
# Double-Buffered DAC Control Register

This block sits between a serial slave protocol parser and a 10-bit voltage-output converter. The parser raises one-cycle strobes when a command byte, a low data byte or a high data byte has been received. It also raises strobes for a bus START, a bus STOP, a broadcast update and a broadcast clear. The block keeps an input stage, made of a command register and a code register, and an output stage of latches. The output latches drive the converter code, the power-down control and the reference-select control.

The command's sync-mode bit chooses when the input stage moves to the output stage. With the bit at 0, the copy happens on a STOP. With the bit at 1, the copy happens only on the shared broadcast update strobe. This lets many converters on one bus change their outputs in the same cycle. A broadcast clear empties both stages in either mode. A data word only reaches the code register once both of its bytes have arrived without a bus interruption between them.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: After reset, dac_code is 0, shutdown is 0, ref_sel is 0, and the block is in STOP-update mode.
- R2: A command byte is decoded as follows. Bit 2 becomes ref_sel (1 = internal reference). Bit 1 becomes shutdown (1 = power down). Bit 0 is the sync mode. Bits 7..3 have no effect.
- R3: The code is assembled with low-byte bits 7..0 as code bits 7..0 and high-byte bits 1..0 as code bits 9..8. High-byte bits 7..2 have no effect.
- R4: With sync mode 0, a STOP copies the input stage to the outputs, which show the new values one cycle after the STOP strobe.
- R5: The outputs change only in an update cycle or a clear cycle. Writes into the input stage leave them unchanged.
- R6: With sync mode 1, a STOP leaves the outputs unchanged.
- R7: With sync mode 1, a broadcast update strobe copies the input stage to the outputs.
- R8: With sync mode 0, a broadcast update strobe has no effect on the outputs.
- R9: A broadcast clear zeroes both stages and returns the block to STOP-update mode, whatever the sync mode. It takes precedence over a STOP or update strobe in the same cycle.
- R10: Shutdown takes effect only at the update, and the code is retained. Clearing shutdown later restores the previously held code.
- R11: A newly received sync-mode bit already governs the STOP of the same transaction.
- R12: A transaction that carries only a command transfers the previously held code along with the new command.
- R13: If a START, a STOP or a new command arrives between the low byte and the high byte, the word is discarded and the code register keeps its prior value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte received strobe |
| cmd_byte | input | 8 | Command byte value |
| lo_valid | input | 1 | Low data byte received strobe |
| lo_byte | input | 8 | Low data byte value |
| hi_valid | input | 1 | High data byte received strobe |
| hi_byte | input | 8 | High data byte value |
| start_evt | input | 1 | Bus START (or repeated START) seen |
| stop_evt | input | 1 | Bus STOP seen |
| sync_upd | input | 1 | Broadcast update strobe |
| sync_clr | input | 1 | Broadcast clear strobe |
| dac_code | output | 10 | Registered converter code |
| shutdown | output | 1 | Registered power-down control |
| ref_sel | output | 1 | Registered reference select, 1 = internal |

## Verification
The assertions check on every cycle that the outputs hold still unless an update or a clear is taking place. They also check that a STOP or an update strobe is ignored or obeyed according to the live sync-mode bit, that an accepted transfer carries the input code, and that a clear always leaves zeros. Only the bench scenarios can show the byte-level decoding of fields, the discarding of interrupted words, the retained code after leaving shutdown, and the return to STOP-update mode after a clear.

// File: rtl/dacreg_pkg.sv
// Package: shared types for the double-buffered converter control register.
// Assumes the command fields are single bits, and their positions are given
// as parameters of the modules.
package dacreg_pkg;

    // Decoded command fields held in either stage.
    typedef struct packed {
        logic ref_int;    // 1 = internal reference
        logic pwr_down;   // 1 = converter powered down
        logic sync_mode;  // 1 = update only on broadcast strobe
    } ctrl_t;

    localparam ctrl_t CTRL_RESET = '{ref_int: 1'b0, pwr_down: 1'b0, sync_mode: 1'b0};

endpackage

// File: rtl/dacreg_input_stage.sv
// Module: dacreg_input_stage
// Holds the input copies of the command and the code. The low data byte is
// staged and committed together with the high byte. A START, a STOP or a new
// command arriving between the two bytes throws the staged byte away.
// Assumes CODE_W > BYTE_W and CODE_W <= 2*BYTE_W.
module dacreg_input_stage
    import dacreg_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int BYTE_W  = 8,
    parameter int REF_BIT = 2,
    parameter int SD_BIT  = 1,
    parameter int SY_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              cmd_we,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              lo_we,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic              hi_we,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic              frame_brk,
    output ctrl_t             ctrl_in,
    output logic [CODE_W-1:0] code_in
);
    localparam int HI_W = CODE_W - BYTE_W;

    logic [BYTE_W-1:0] lo_hold;
    logic              lo_held;
    ctrl_t             cmd_dec;

    // Extract the command fields from their fixed bit positions.
    always_comb begin
        cmd_dec.ref_int   = cmd_byte[REF_BIT];
        cmd_dec.pwr_down  = cmd_byte[SD_BIT];
        cmd_dec.sync_mode = cmd_byte[SY_BIT];
    end

    // Input command register: loaded on each received command byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ctrl_in <= CTRL_RESET;
        end else if (cmd_we) begin
            ctrl_in <= cmd_dec;
        end
    end

    // Low-byte staging: armed by a low byte, disarmed by a frame break,
    // a new command or the committing high byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            lo_hold <= '0;
            lo_held <= 1'b0;
        end else if (frame_brk || cmd_we) begin
            lo_held <= 1'b0;
        end else if (lo_we) begin
            lo_hold <= lo_byte;
            lo_held <= 1'b1;
        end else if (hi_we) begin
            lo_held <= 1'b0;
        end
    end

    // Input code register: written only when a complete word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            code_in <= '0;
        end else if (hi_we && lo_held && !frame_brk && !cmd_we) begin
            code_in <= {hi_byte[HI_W-1:0], lo_hold};
        end
    end

endmodule

// File: rtl/dacreg_xfer_ctrl.sv
// Module: dacreg_xfer_ctrl
// Decides, each cycle, whether the output stage loads from the input stage
// or is cleared. Clear wins over any load strobe in the same cycle.
// Assumes all event inputs are single-cycle strobes.
module dacreg_xfer_ctrl (
    input  logic stop_evt,
    input  logic sync_upd,
    input  logic sync_clr,
    input  logic sync_mode,
    output logic load,
    output logic clear
);
    // Select the transfer source from the live sync-mode bit.
    always_comb begin
        clear = sync_clr;
        if (sync_clr) begin
            load = 1'b0;
        end else if (sync_mode) begin
            load = sync_upd;
        end else begin
            load = stop_evt;
        end
    end

endmodule

// File: rtl/dacreg_output_stage.sv
// Module: dacreg_output_stage
// Output latches that drive the converter code, the power-down control and
// the reference select. They change only in a load or a clear cycle.
module dacreg_output_stage
    import dacreg_pkg::*;
#(
    parameter int CODE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  ctrl_t             ctrl_in,
    input  logic [CODE_W-1:0] code_in,
    output logic [CODE_W-1:0] dac_code,
    output logic              shutdown,
    output logic              ref_sel
);
    // Output latch update: clear to zero, or copy the input stage.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            dac_code <= '0;
            shutdown <= 1'b0;
            ref_sel  <= 1'b0;
        end else if (load) begin
            dac_code <= code_in;
            shutdown <= ctrl_in.pwr_down;
            ref_sel  <= ctrl_in.ref_int;
        end
    end

endmodule

// File: rtl/dac_dbuf_ctrl.sv
// Module: dac_dbuf_ctrl (top)
// Double-buffered control register for a voltage-output converter, fed by
// the strobes of a serial slave parser. Assumes at most one byte strobe per
// cycle, and that the parser has already filtered the addresses.
module dac_dbuf_ctrl
    import dacreg_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int BYTE_W  = 8,
    parameter int REF_BIT = 2,
    parameter int SD_BIT  = 1,
    parameter int SY_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              lo_valid,
    input  logic [BYTE_W-1:0] lo_byte,
    input  logic              hi_valid,
    input  logic [BYTE_W-1:0] hi_byte,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              sync_upd,
    input  logic              sync_clr,
    output logic [CODE_W-1:0] dac_code,
    output logic              shutdown,
    output logic              ref_sel
);
    ctrl_t             ctrl_in;
    logic [CODE_W-1:0] code_in;
    logic              sync_mode_q;
    logic              load;
    logic              clear;
    logic              frame_brk;

    assign frame_brk   = start_evt | stop_evt;
    assign sync_mode_q = ctrl_in.sync_mode;

    dacreg_input_stage #(
        .CODE_W (CODE_W),
        .BYTE_W (BYTE_W),
        .REF_BIT(REF_BIT),
        .SD_BIT (SD_BIT),
        .SY_BIT (SY_BIT)
    ) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clear),
        .cmd_we   (cmd_valid),
        .cmd_byte (cmd_byte),
        .lo_we    (lo_valid),
        .lo_byte  (lo_byte),
        .hi_we    (hi_valid),
        .hi_byte  (hi_byte),
        .frame_brk(frame_brk),
        .ctrl_in  (ctrl_in),
        .code_in  (code_in)
    );

    dacreg_xfer_ctrl u_xfer (
        .stop_evt (stop_evt),
        .sync_upd (sync_upd),
        .sync_clr (sync_clr),
        .sync_mode(sync_mode_q),
        .load     (load),
        .clear    (clear)
    );

    dacreg_output_stage #(
        .CODE_W(CODE_W)
    ) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .clear   (clear),
        .ctrl_in (ctrl_in),
        .code_in (code_in),
        .dac_code(dac_code),
        .shutdown(shutdown),
        .ref_sel (ref_sel)
    );

endmodule

// File: rtl/dacreg_checker.sv
// Module: dacreg_checker
// Temporal checks on the transfer rules, bound to the top module.
module dacreg_checker #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_evt,
    input logic              sync_upd,
    input logic              sync_clr,
    input logic              sync_mode,
    input logic [CODE_W-1:0] code_in,
    input logic [CODE_W-1:0] dac_code,
    input logic              shutdown,
    input logic              ref_sel
);
    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        sync_clr |=> (dac_code == '0 && !shutdown && !ref_sel)); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_evt && !sync_upd && !sync_clr) |=> $stable({dac_code, shutdown, ref_sel})); // R5
    AST_STOP_IGNORED_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && sync_mode && !sync_upd && !sync_clr) |=> $stable({dac_code, shutdown, ref_sel})); // R6
    AST_UPD_IGNORED_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_upd && !sync_mode && !stop_evt && !sync_clr) |=> $stable({dac_code, shutdown, ref_sel})); // R8
    AST_STOP_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_evt && !sync_mode && !sync_clr) |=> (dac_code == $past(code_in))); // R4
    AST_UPD_LOADS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_upd && sync_mode && !sync_clr) |=> (dac_code == $past(code_in))); // R7
endmodule

bind dac_dbuf_ctrl dacreg_checker #(.CODE_W(CODE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_evt (stop_evt),
    .sync_upd (sync_upd),
    .sync_clr (sync_clr),
    .sync_mode(sync_mode_q),
    .code_in  (code_in),
    .dac_code (dac_code),
    .shutdown (shutdown),
    .ref_sel  (ref_sel)
);

// File: tb/sim_dac_dbuf_ctrl.sv
// Scoreboard bench: the driver tasks keep a requirement-level model and
// push expected output items; a monitor pops and compares them at negedges.
module sim_dac_dbuf_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, lo_valid = 1'b0, hi_valid = 1'b0;
    logic [7:0] cmd_byte = '0, lo_byte = '0, hi_byte = '0;
    logic       start_evt = 1'b0, stop_evt = 1'b0, sync_upd = 1'b0, sync_clr = 1'b0;
    logic [9:0] dac_code;
    logic       shutdown, ref_sel;

    dac_dbuf_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
        .lo_valid(lo_valid), .lo_byte(lo_byte),
        .hi_valid(hi_valid), .hi_byte(hi_byte),
        .start_evt(start_evt), .stop_evt(stop_evt),
        .sync_upd(sync_upd), .sync_clr(sync_clr),
        .dac_code(dac_code), .shutdown(shutdown), .ref_sel(ref_sel)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [9:0] code;
        logic       sd;
        logic       rf;
        string      tag;
    } exp_t;

    exp_t q[$];
    exp_t e;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    // Requirement-level model state.
    logic       m_sy = 0, m_sd = 0, m_rf = 0, m_lo_ok = 0;
    logic [7:0] m_lo = 0;
    logic [9:0] m_code = 0;
    logic [9:0] o_code = 0;
    logic       o_sd = 0, o_rf = 0;

    task automatic expect_out(input string tag);
        exp_t x;
        x.code = o_code; x.sd = o_sd; x.rf = o_rf; x.tag = tag;
        q.push_back(x);
        @(negedge clk);
    endtask

    task automatic copy_out();
        o_code = m_code; o_sd = m_sd; o_rf = m_rf;
    endtask

    task automatic do_cmd(input logic [7:0] b);
        @(negedge clk); cmd_valid = 1; cmd_byte = b;
        @(negedge clk); cmd_valid = 0;
        m_rf = b[2]; m_sd = b[1]; m_sy = b[0]; m_lo_ok = 0;
    endtask

    task automatic do_lo(input logic [7:0] b);
        @(negedge clk); lo_valid = 1; lo_byte = b;
        @(negedge clk); lo_valid = 0;
        m_lo = b; m_lo_ok = 1;
    endtask

    task automatic do_hi(input logic [7:0] b);
        @(negedge clk); hi_valid = 1; hi_byte = b;
        @(negedge clk); hi_valid = 0;
        if (m_lo_ok) m_code = {b[1:0], m_lo};
        m_lo_ok = 0;
    endtask

    task automatic do_start();
        @(negedge clk); start_evt = 1;
        @(negedge clk); start_evt = 0;
        m_lo_ok = 0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_evt = 1;
        @(negedge clk); stop_evt = 0;
        m_lo_ok = 0;
        if (!m_sy) copy_out();
    endtask

    task automatic do_upd();
        @(negedge clk); sync_upd = 1;
        @(negedge clk); sync_upd = 0;
        if (m_sy) copy_out();
    endtask

    task automatic clear_model();
        m_sy = 0; m_sd = 0; m_rf = 0; m_lo_ok = 0; m_lo = 0; m_code = 0;
        o_code = 0; o_sd = 0; o_rf = 0;
    endtask

    task automatic do_clr(input bit with_stop, input bit with_upd);
        @(negedge clk); sync_clr = 1; stop_evt = with_stop; sync_upd = with_upd;
        @(negedge clk); sync_clr = 0; stop_evt = 0; sync_upd = 0;
        clear_model();
    endtask

    task automatic word(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi);
        do_cmd(c); do_lo(lo); do_hi(hi);
    endtask

    // Monitor: compares the outputs with each queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                n_chk++;
                if (dac_code !== e.code || shutdown !== e.sd || ref_sel !== e.rf) begin
                    n_fail++;
                    $display("FAIL %s: actual code=%h sd=%b ref=%b expected code=%h sd=%b ref=%b",
                             e.tag, dac_code, shutdown, ref_sel, e.code, e.sd, e.rf);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        expect_out("R1 reset state");

        // R4/R3/R5: basic word, outputs wait for STOP.
        word(8'h00, 8'h5A, 8'h03);
        expect_out("R5 no change before update");
        do_stop();
        expect_out("R4 STOP transfer");
        word(8'h00, 8'hFF, 8'hFE);
        do_stop();
        expect_out("R3 high byte upper bits ignored");

        // R2/R12: command-only with bits 7..3 set, reference set.
        do_cmd(8'hFC); do_stop();
        expect_out("R2 R12 command-only transfer");
        word(8'h00, 8'h10, 8'h00); do_stop();
        expect_out("R2 upper command bits did not set sync mode");

        // R10: shutdown deferred to STOP, code retained and restored.
        word(8'h00, 8'hA5, 8'h02); do_stop();
        do_cmd(8'h02);
        expect_out("R10 shutdown waits for STOP");
        do_stop();
        expect_out("R10 shutdown applied with code kept");
        do_cmd(8'h00); do_stop();
        expect_out("R10 leaving shutdown restores code");

        // R11/R6/R7: sync mode set in the same transaction.
        word(8'h05, 8'h11, 8'h01); do_stop();
        expect_out("R11 R6 STOP ignored in sync mode");
        do_upd();
        expect_out("R7 broadcast update transfers");

        // R8: update ignored in normal mode.
        word(8'h00, 8'h22, 8'h00); do_upd();
        expect_out("R8 update ignored in normal mode");
        do_stop();
        expect_out("R4 STOP after ignored update");

        // R13: interrupted words discarded.
        word(8'h00, 8'h77, 8'h00);
        do_stop();
        do_cmd(8'h00); do_lo(8'h77); do_start(); do_hi(8'h03); do_stop();
        expect_out("R13 START between data bytes discards word");
        do_cmd(8'h00); do_lo(8'h44); do_stop(); do_hi(8'h01); do_stop();
        expect_out("R13 STOP between data bytes discards word");
        do_cmd(8'h00); do_lo(8'h66); do_cmd(8'h00); do_hi(8'h02); do_stop();
        expect_out("R13 new command between data bytes discards word");

        // R9: clear in normal mode, in sync mode, and with a STOP in the same cycle.
        word(8'h04, 8'h3C, 8'h01); do_stop();
        do_clr(0, 0);
        expect_out("R9 clear in normal mode");
        word(8'h07, 8'h0F, 8'h03); do_upd();
        expect_out("R7 update in sync mode with shutdown");
        do_cmd(8'h05); do_clr(0, 0);
        expect_out("R9 clear in sync mode");
        do_stop();
        expect_out("R9 clear emptied input stage");
        word(8'h00, 8'h33, 8'h00); do_stop();
        expect_out("R9 mode back to STOP update");
        word(8'h04, 8'h99, 8'h02);
        do_clr(1, 0);
        expect_out("R9 clear wins over STOP");
        word(8'h05, 8'h12, 8'h01);
        do_clr(0, 1);
        expect_out("R9 clear wins over update");

        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule